// File: doc/BRIEF.md
# Virtual DMA PIO Transfer Controller

This block is the transfer engine for one IDE channel. It lets software drive programmed-I/O data phases through a DMA-style command and status model. Software loads a byte count for the next burst, selects a direction and sets the start bit. The engine then moves 16-bit words between a buffer-side stream and the device data register. It performs one PIO handshake per word and runs until the count is used up. Each interrupt-driven chunk of a command is its own burst with its own count.

Completion is reported in three places: a virtual-DMA-complete flag, a DMA-done bit and a sticky error bit. All three use write-1-to-clear. Device interrupts are latched on their own and survive the clearing of the completion flags, so an interrupt that races with a burst's end is not lost. While no burst is running, the DMA-done bit also captures device interrupts. A host interrupt is asserted while interrupts are enabled and either the completion flag or the device interrupt latch is set.

The engine is a state machine with these states:
- IDLE
- WAIT_DRQ: waits for the device to be ready for the next word.
- FETCH: takes a word from the buffer stream.
- PIO: device handshake.
- PUSH: hands a word to the buffer stream.
- DONE
- ABORT

Its transitions are:
- start: IDLE to WAIT_DRQ, or IDLE to DONE when the count is zero.
- ready: WAIT_DRQ to FETCH for writes, or to PIO for reads.
- fetched: FETCH to PIO.
- acked: PIO to PUSH for reads; for writes, PIO to WAIT_DRQ, or to DONE on the last word.
- pushed: PUSH to WAIT_DRQ, or to DONE on the last word.
- error: WAIT_DRQ to ABORT.
- cancel: any busy state to IDLE.
- retire: DONE or ABORT to IDLE.

Top module: `vdma_pio_chan`

## Requirements
- R1: After reset every register reads zero except the task-file word (address 1), which shows the device status byte. No PIO request or buffer strobe is active, and `host_irq` is low.
- R2: A write to the command register (address 0) with bit 0 set starts a burst while the engine is idle. Bit 3 selects the direction: 1 is device-to-host, 0 is host-to-device. Bit 16 of address 0 reads 1 while the engine is busy.
- R3: Each word waits for DRQ, which is device status bit 3 and task-file bit 27. Each word then takes one `pio_req`/`pio_ack` handshake. A host-to-device word is first taken from the buffer stream, and a device-to-host word is afterwards handed to the buffer stream in order. No strobe is issued while idle.
- R4: The byte count (address 3) drops by 2 per word and never wraps. An odd count moves ceil(N/2) words, dropping the surplus byte, and the count reads 0 at the end.
- R5: When the count is exhausted the engine sets the completion flag (address 2 bit 10) and the done bit (address 0 bit 18), and goes idle.
- R6: A rising edge of `dev_intrq` sets the device interrupt latch (address 2 bit 11). Only a read of address 1 clears it, and writes of 1 to address 0 bits 18:17 leave it set.
- R7: A device interrupt edge while idle also sets address 0 bit 18. An edge while busy does not set it.
- R8: Writing 1 to address 0 bit 18 clears only the done bit. Writing 1 to bit 17 clears the error bit and the completion flag.
- R9: ERR (device status bit 0, task-file bit 24) seen while waiting for DRQ aborts the burst. The abort sets address 0 bits 17 and 18 and address 2 bit 10, zeroes the count and issues no strobe.
- R10: A write of zero to address 0 bits 7:0 during a burst cancels it. The cancel sets no flag, keeps the remaining count and issues no further strobe.
- R11: `host_irq` equals the enable bit (address 2 bit 1) ANDed with the OR of address 2 bits 10 and 11.
- R12: A write to the byte count while busy is ignored.
- R13: Starting with a count of zero completes at once with no strobe, setting bits 10 and 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| host_irq | output | 1 | Host interrupt |
| buf_rd_valid | input | 1 | Buffer word available for host-to-device |
| buf_rd_ready | output | 1 | Engine takes the buffer word |
| buf_rd_data | input | DATA_W | Buffer word to the device |
| buf_wr_valid | output | 1 | Word from the device available |
| buf_wr_ready | input | 1 | Buffer accepts the word |
| buf_wr_data | output | DATA_W | Word from the device |
| dev_intrq | input | 1 | Device interrupt line |
| dev_status | input | 8 | Device status byte (bit 3 DRQ, bit 0 ERR) |
| pio_req | output | 1 | PIO cycle request, held until acknowledged |
| pio_we | output | 1 | PIO direction, 1 writes the device |
| pio_wdata | output | DATA_W | Data to the device |
| pio_rdata | input | DATA_W | Data from the device, valid with the acknowledge |
| pio_ack | input | 1 | PIO cycle acknowledge |

## Verification
An odd byte count is a key corner: a design that rounds down loses the last word, and one that wraps underflows into a near-endless burst. Device interrupts are driven both inside and outside a burst and then cleared through the command register. A design that ties the interrupt latch to the write-1-to-clear path loses the racing interrupt, and one that mirrors the interrupt into the done bit while busy reports a false completion. Count writes during a stalled burst, a cancel followed by a raised DRQ, an ERR abort and a zero-count start catch the remaining faults: count corruption, stray strobes after a cancel, a transfer despite the error, and a hang on an empty burst.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int REG_W = 32;

    localparam int A_CMD = 0;
    localparam int A_TFS = 1;
    localparam int A_CHS = 2;
    localparam int A_CNT = 3;

    localparam int B_START  = 0;
    localparam int B_DIR    = 3;
    localparam int B_BUSY   = 16;
    localparam int B_ERR    = 17;
    localparam int B_DONE   = 18;
    localparam int B_IRQEN  = 1;
    localparam int B_VDONE  = 10;
    localparam int B_DEVIRQ = 11;

    localparam int S_ERR = 0;
    localparam int S_DRQ = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_DRQ,
        ST_FETCH,
        ST_PIO,
        ST_PUSH,
        ST_DONE,
        ST_ABORT
    } eng_state_t;

endpackage

// File: rtl/vdma_pio_fsm.sv
module vdma_pio_fsm
    import vdma_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              dir_rd,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              drq,
    input  logic              err,
    input  logic              buf_rd_valid,
    input  logic [DATA_W-1:0] buf_rd_data,
    input  logic              buf_wr_ready,
    input  logic              pio_ack,
    input  logic [DATA_W-1:0] pio_rdata,
    output logic              busy,
    output logic              done_p,
    output logic              abort_p,
    output logic              word_done,
    output logic [CNT_W-1:0]  count,
    output logic              buf_rd_ready,
    output logic              buf_wr_valid,
    output logic [DATA_W-1:0] buf_wr_data,
    output logic              pio_req,
    output logic              pio_we,
    output logic [DATA_W-1:0] pio_wdata
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(DATA_W / 8);

    eng_state_t        state_q, state_d;
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] word_q;
    logic              dir_q;
    logic              last_word;

    assign last_word = (count_q <= STEP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (count_q == '0) ? ST_DONE : ST_WAIT_DRQ;
                end
            end
            ST_WAIT_DRQ: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end else if (err) begin
                    state_d = ST_ABORT;
                end else if (drq) begin
                    state_d = dir_q ? ST_PIO : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end else if (buf_rd_valid) begin
                    state_d = ST_PIO;
                end
            end
            ST_PIO: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end else if (pio_ack) begin
                    if (dir_q) begin
                        state_d = ST_PUSH;
                    end else begin
                        state_d = last_word ? ST_DONE : ST_WAIT_DRQ;
                    end
                end
            end
            ST_PUSH: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end else if (buf_wr_ready) begin
                    state_d = last_word ? ST_DONE : ST_WAIT_DRQ;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        done_p       = (state_q == ST_DONE);
        abort_p      = (state_q == ST_ABORT);
        buf_rd_ready = (state_q == ST_FETCH);
        buf_wr_valid = (state_q == ST_PUSH);
        pio_req      = (state_q == ST_PIO);
        pio_we       = !dir_q;
        pio_wdata    = word_q;
        buf_wr_data  = word_q;
        word_done    = !stop &&
                       (((state_q == ST_PIO) && pio_ack && !dir_q) ||
                        ((state_q == ST_PUSH) && buf_wr_ready));
    end

    // datapath: count, direction, word holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            dir_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            if ((state_q == ST_IDLE) && cnt_wr) begin
                count_q <= cnt_wdata;
            end else if (state_q == ST_ABORT) begin
                count_q <= '0;
            end else if (word_done) begin
                count_q <= last_word ? '0 : (count_q - STEP);
            end
            if ((state_q == ST_IDLE) && start) begin
                dir_q <= dir_rd;
            end
            if ((state_q == ST_FETCH) && buf_rd_valid) begin
                word_q <= buf_rd_data;
            end else if ((state_q == ST_PIO) && pio_ack && dir_q) begin
                word_q <= pio_rdata;
            end
        end
    end

    assign count = count_q;

endmodule

// File: rtl/vdma_status_regs.sv
module vdma_status_regs
    import vdma_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              done_p,
    input  logic              abort_p,
    input  logic [CNT_W-1:0]  count,
    input  logic [7:0]        dev_status,
    input  logic              dev_intrq,
    output logic              start,
    output logic              stop,
    output logic              dir_rd,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              irq_en,
    output logic              devirq,
    output logic              vdone,
    output logic              err_flag,
    output logic              host_irq
);

    logic       wr_cmd, wr_chs, rd_tfs;
    logic [7:0] cmd_q;
    logic       done_q, err_q, vdone_q, devirq_q, irq_en_q, intrq_q;
    logic       intrq_rise;

    assign wr_cmd     = reg_wr && (reg_addr == ADDR_W'(A_CMD));
    assign wr_chs     = reg_wr && (reg_addr == ADDR_W'(A_CHS));
    assign rd_tfs     = reg_rd && (reg_addr == ADDR_W'(A_TFS));
    assign cnt_wr     = reg_wr && (reg_addr == ADDR_W'(A_CNT));
    assign cnt_wdata  = reg_wdata[CNT_W-1:0];
    assign intrq_rise = dev_intrq && !intrq_q;

    assign start  = wr_cmd && reg_wdata[B_START] && !busy;
    assign stop   = wr_cmd && (reg_wdata[7:0] == 8'h00) && busy;
    assign dir_rd = reg_wdata[B_DIR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            vdone_q  <= 1'b0;
            devirq_q <= 1'b0;
            irq_en_q <= 1'b0;
            intrq_q  <= 1'b0;
        end else begin
            intrq_q <= dev_intrq;
            if (wr_cmd) begin
                cmd_q <= reg_wdata[7:0];
            end
            if (wr_chs) begin
                irq_en_q <= reg_wdata[B_IRQEN];
            end
            // set has priority over clear on every flag
            if (done_p || abort_p || (intrq_rise && !busy)) begin
                done_q <= 1'b1;
            end else if (wr_cmd && reg_wdata[B_DONE]) begin
                done_q <= 1'b0;
            end
            if (abort_p) begin
                err_q <= 1'b1;
            end else if (wr_cmd && reg_wdata[B_ERR]) begin
                err_q <= 1'b0;
            end
            if (done_p || abort_p) begin
                vdone_q <= 1'b1;
            end else if (wr_cmd && reg_wdata[B_ERR]) begin
                vdone_q <= 1'b0;
            end
            if (intrq_rise) begin
                devirq_q <= 1'b1;
            end else if (rd_tfs) begin
                devirq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_CMD): begin
                reg_rdata[7:0]    = cmd_q;
                reg_rdata[B_BUSY] = busy;
                reg_rdata[B_ERR]  = err_q;
                reg_rdata[B_DONE] = done_q;
            end
            ADDR_W'(A_TFS): begin
                reg_rdata[31:24] = dev_status;
            end
            ADDR_W'(A_CHS): begin
                reg_rdata[B_IRQEN]  = irq_en_q;
                reg_rdata[B_VDONE]  = vdone_q;
                reg_rdata[B_DEVIRQ] = devirq_q;
            end
            default: begin
                reg_rdata = REG_W'(count);
            end
        endcase
    end

    assign irq_en   = irq_en_q;
    assign devirq   = devirq_q;
    assign vdone    = vdone_q;
    assign err_flag = err_q;
    assign host_irq = irq_en_q && (vdone_q || devirq_q);

endmodule

// File: rtl/vdma_pio_chan.sv
module vdma_pio_chan
    import vdma_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              host_irq,
    input  logic              buf_rd_valid,
    output logic              buf_rd_ready,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic              buf_wr_valid,
    input  logic              buf_wr_ready,
    output logic [DATA_W-1:0] buf_wr_data,
    input  logic              dev_intrq,
    input  logic [7:0]        dev_status,
    output logic              pio_req,
    output logic              pio_we,
    output logic [DATA_W-1:0] pio_wdata,
    input  logic [DATA_W-1:0] pio_rdata,
    input  logic              pio_ack
);

    logic             start_w, stop_w, dir_rd_w, cnt_wr_w;
    logic [CNT_W-1:0] cnt_wdata_w, count_w;
    logic             busy_w, done_w, abort_w, word_done_w;
    logic             irq_en_w, devirq_w, vdone_w, err_w;

    vdma_status_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy_w),
        .done_p     (done_w),
        .abort_p    (abort_w),
        .count      (count_w),
        .dev_status (dev_status),
        .dev_intrq  (dev_intrq),
        .start      (start_w),
        .stop       (stop_w),
        .dir_rd     (dir_rd_w),
        .cnt_wr     (cnt_wr_w),
        .cnt_wdata  (cnt_wdata_w),
        .irq_en     (irq_en_w),
        .devirq     (devirq_w),
        .vdone      (vdone_w),
        .err_flag   (err_w),
        .host_irq   (host_irq)
    );

    vdma_pio_fsm #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start_w),
        .stop         (stop_w),
        .dir_rd       (dir_rd_w),
        .cnt_wr       (cnt_wr_w),
        .cnt_wdata    (cnt_wdata_w),
        .drq          (dev_status[S_DRQ]),
        .err          (dev_status[S_ERR]),
        .buf_rd_valid (buf_rd_valid),
        .buf_rd_data  (buf_rd_data),
        .buf_wr_ready (buf_wr_ready),
        .pio_ack      (pio_ack),
        .pio_rdata    (pio_rdata),
        .busy         (busy_w),
        .done_p       (done_w),
        .abort_p      (abort_w),
        .word_done    (word_done_w),
        .count        (count_w),
        .buf_rd_ready (buf_rd_ready),
        .buf_wr_valid (buf_wr_valid),
        .buf_wr_data  (buf_wr_data),
        .pio_req      (pio_req),
        .pio_we       (pio_we),
        .pio_wdata    (pio_wdata)
    );

endmodule

// File: rtl/vdma_pio_chan_chk.sv
module vdma_pio_chan_chk
    import vdma_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              busy,
    input logic              word_done,
    input logic              abort_p,
    input logic [CNT_W-1:0]  count,
    input logic              pio_req,
    input logic              buf_rd_ready,
    input logic              buf_wr_valid,
    input logic              devirq,
    input logic              err_flag,
    input logic              irq_en,
    input logic              host_irq
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(DATA_W / 8);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pio_req && !buf_rd_ready && !buf_wr_valid)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (count == (($past(count) > STEP) ? ($past(count) - STEP) : '0))); // R4

    AST_DEVIRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (devirq && !(reg_rd && (reg_addr == ADDR_W'(A_TFS)))) |=> devirq); // R6

    AST_ERR_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !busy); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !host_irq); // R11

    AST_COUNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !word_done && !abort_p) |=> $stable(count)); // R12

endmodule

bind vdma_pio_chan vdma_pio_chan_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .busy         (busy_w),
    .word_done    (word_done_w),
    .abort_p      (abort_w),
    .count        (count_w),
    .pio_req      (pio_req),
    .buf_rd_ready (buf_rd_ready),
    .buf_wr_valid (buf_wr_valid),
    .devirq       (devirq_w),
    .err_flag     (err_w),
    .irq_en       (irq_en_w),
    .host_irq     (host_irq)
);

// File: tb/vdma_pio_chan_tb_top.sv
`timescale 1ns/1ps
module vdma_pio_chan_tb_top;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              host_irq;
    logic              buf_rd_valid = 1'b1;
    logic              buf_rd_ready;
    logic [DATA_W-1:0] buf_rd_data;
    logic              buf_wr_valid;
    logic              buf_wr_ready = 1'b1;
    logic [DATA_W-1:0] buf_wr_data;
    logic              dev_intrq = 1'b0;
    logic [7:0]        dev_status = 8'h08;
    logic              pio_req;
    logic              pio_we;
    logic [DATA_W-1:0] pio_wdata;
    logic [DATA_W-1:0] pio_rdata;
    logic              pio_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int src_idx = 0;
    int dev_idx = 0;
    int strobes = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] exp_q[$];

    always #2 clk = ~clk;

    vdma_pio_chan dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_irq(host_irq), .buf_rd_valid(buf_rd_valid),
        .buf_rd_ready(buf_rd_ready), .buf_rd_data(buf_rd_data),
        .buf_wr_valid(buf_wr_valid), .buf_wr_ready(buf_wr_ready),
        .buf_wr_data(buf_wr_data), .dev_intrq(dev_intrq),
        .dev_status(dev_status), .pio_req(pio_req), .pio_we(pio_we),
        .pio_wdata(pio_wdata), .pio_rdata(pio_rdata), .pio_ack(pio_ack)
    );

    assign buf_rd_data = 16'hA000 + DATA_W'(src_idx);
    assign pio_rdata   = 16'h5000 + DATA_W'(dev_idx);

    // device and buffer models
    always @(posedge clk) begin
        pio_ack <= pio_req && !pio_ack;
        if (buf_rd_ready && buf_rd_valid) src_idx <= src_idx + 1;
        if (pio_req && pio_ack) begin
            strobes <= strobes + 1;
            if (!pio_we) dev_idx <= dev_idx + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (pio_req && pio_ack && pio_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected device write", {16'h0, pio_wdata}, 32'h0);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    check(pio_wdata == e, "R3", "device write word", {16'h0, pio_wdata}, {16'h0, e});
                end
            end
            if (buf_wr_valid && buf_wr_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected buffer word", {16'h0, buf_wr_data}, 32'h0);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    check(buf_wr_data == e, "R3", "buffer word", {16'h0, buf_wr_data}, {16'h0, e});
                end
            end
        end
    end

    task automatic expect_write(input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(16'hA000 + DATA_W'(src_idx + k));
    endtask

    task automatic expect_read(input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(16'h5000 + DATA_W'(dev_idx + k));
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(0, v);
            if (!v[16]) return;
        end
        check(1'b0, "R5", "burst never ended", v, 32'h0);
    endtask

    task automatic pulse_intrq();
        @(negedge clk); dev_intrq = 1'b1;
        repeat (2) @(negedge clk);
        dev_intrq = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v); check(v == 0, "R1", "cmd after reset", v, 0);
        rd(2, v); check(v == 0, "R1", "chan after reset", v, 0);
        rd(3, v); check(v == 0, "R1", "count after reset", v, 0);
        rd(1, v); check(v == 32'h0800_0000, "R1", "taskfile status", v, 32'h0800_0000);
        check(host_irq == 1'b0, "R1", "irq after reset", {31'h0, host_irq}, 0);

        // R2 R3 R4 R5: host-to-device burst of three words
        wr(2, 32'h2);
        wr(3, 6);
        expect_write(3);
        wr(0, 32'h01);
        rd(0, v); check(v[16] == 1'b1, "R2", "busy after start", v, 32'h0001_0001);
        wait_idle();
        rd(3, v); check(v == 0, "R4", "count exhausted", v, 0);
        rd(0, v); check(v[18:16] == 3'b100, "R5", "done bits", {29'h0, v[18:16]}, 32'h4);
        rd(2, v); check(v[11:10] == 2'b01, "R5", "vdone flag", {30'h0, v[11:10]}, 32'h1);
        check(host_irq == 1'b1, "R11", "irq on completion", {31'h0, host_irq}, 1);
        check(exp_q.size() == 0, "R3", "write words left", exp_q.size(), 0);

        // R8 clear bit 18 alone, then bit 17
        wr(0, 32'h0004_0000);
        rd(0, v); check(v[18] == 1'b0, "R8", "done cleared", v, 0);
        rd(2, v); check(v[10] == 1'b1, "R8", "vdone kept by bit18 clear", v, 32'h402);
        wr(0, 32'h0002_0000);
        rd(2, v); check(v[10] == 1'b0, "R8", "vdone cleared by bit17", v, 32'h2);
        check(host_irq == 1'b0, "R11", "irq after clear", {31'h0, host_irq}, 0);

        // R4 odd count, device-to-host
        wr(3, 5);
        expect_read(3);
        wr(0, 32'h09);
        wait_idle();
        rd(3, v); check(v == 0, "R4", "odd count exhausted", v, 0);
        check(exp_q.size() == 0, "R4", "odd count word total", exp_q.size(), 0);
        wr(0, 32'h0006_0000);

        // R12 R7 R10 stalled burst
        dev_status = 8'h00;
        wr(3, 4);
        wr(0, 32'h09);
        wr(3, 100);
        rd(3, v); check(v == 4, "R12", "count write while busy", v, 4);
        pulse_intrq();
        rd(0, v); check(v[18] == 1'b0, "R7", "no mirror while busy", v, 0);
        rd(2, v); check(v[11] == 1'b1, "R6", "devirq latched", v, 32'h802);
        s0 = strobes;
        wr(0, 32'h0);
        rd(0, v); check(v[18:16] == 3'b000, "R10", "cancel flags", {29'h0, v[18:16]}, 0);
        dev_status = 8'h08;
        repeat (10) @(negedge clk);
        check(strobes == s0, "R10", "strobes after cancel", strobes, s0);
        rd(3, v); check(v == 4, "R10", "count kept on cancel", v, 4);
        rd(2, v); check(v[10] == 1'b0, "R10", "no vdone on cancel", v, 0);

        // R6 latch survives w1c, cleared by status read
        wr(0, 32'h0006_0000);
        rd(2, v); check(v[11] == 1'b1, "R6", "devirq after w1c", v, 32'h802);
        rd(1, v); check(v == 32'h0800_0000, "R6", "status read", v, 32'h0800_0000);
        rd(2, v); check(v[11] == 1'b0, "R6", "devirq after status read", v, 32'h2);

        // R7 mirror while idle
        pulse_intrq();
        rd(0, v); check(v[18] == 1'b1, "R7", "mirror while idle", v, 32'h0004_0000);
        check(host_irq == 1'b1, "R11", "irq from devirq", {31'h0, host_irq}, 1);
        wr(0, 32'h0004_0000);
        rd(2, v); check(v[11] == 1'b1, "R6", "devirq after bit18 clear", v, 32'h802);
        wr(2, 32'h0);
        check(host_irq == 1'b0, "R11", "irq disabled", {31'h0, host_irq}, 0);
        rd(1, v);
        wr(2, 32'h2);

        // R9 error abort
        dev_status = 8'h09;
        s0 = strobes;
        wr(3, 8);
        wr(0, 32'h01);
        wait_idle();
        rd(0, v); check(v[18:16] == 3'b110, "R9", "abort bits", {29'h0, v[18:16]}, 32'h6);
        rd(3, v); check(v == 0, "R9", "count zeroed", v, 0);
        rd(2, v); check(v[10] == 1'b1, "R9", "vdone on abort", v, 32'h402);
        check(strobes == s0, "R9", "no strobe on abort", strobes, s0);
        wr(0, 32'h0006_0000);
        dev_status = 8'h08;

        // R13 zero count
        s0 = strobes;
        wr(3, 0);
        wr(0, 32'h01);
        wait_idle();
        rd(0, v); check(v[18] == 1'b1, "R13", "done on zero count", v, 32'h0004_0001);
        rd(2, v); check(v[10] == 1'b1, "R13", "vdone on zero count", v, 32'h402);
        check(strobes == s0, "R13", "no strobe on zero count", strobes, s0);
        wr(0, 32'h0006_0000);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule